// File: doc/BRIEF.md
# Bit-Serial SIMD Pixel Processor Array

The block is a rectangular mesh of processing elements, one per image pixel. Each element owns a 128-bit memory column that its one-bit logic reads and writes directly, by row, with no column address. One control word arrives every clock and every element executes it in lockstep. Each instruction reads two memory rows, forms a three-input boolean result from a memory bit, a selected neighbour bit and the element's carry bit, and writes a memory row. A multi-bit operation such as addition is carried out one bit per cycle, with the carry passed from one bit to the next through the carry bit.

Elements exchange one bit with their north, south, east and west neighbours. The bits on the array border leave on edge output ports and arrive on edge input ports. Several arrays can therefore be wired side by side into one larger mesh, and an edge input tied low reads as zero. Image data enters and leaves through a row-wise shift. Each shift moves every row one column east: the west edge inputs feed column 0, and the east edge outputs present the last column.

A per-element activity flag masks the logic operation. The flag can be loaded from any computed bit, so data-dependent work runs on a subset of pixels.

Top module: `pixel_array`

## Requirements
- R1: After reset every memory bit and every carry bit is 0 and every activity flag is 1, so all edge outputs read 0 for any row address.
- R2: op_i=1 (logic op): each active element forms idx={a,n,c}, where a=mem[addr_a_i] (bit 2), n=the selected neighbour bit (bit 1) and c=carry (bit 0). It writes sum_tt_i[idx] to mem[dst_i] and loads carry with carry_tt_i[idx] at the clock edge.
- R3: nsel_i picks the neighbour bit n, always taken at row addr_b_i: 0 = own bit, 1 = north (row index minus 1), 2 = east (column plus 1), 3 = south (row plus 1), 4 = west (column minus 1); codes 5 to 7 act as 0.
- R4: An element on the array border takes an off-array neighbour bit from the matching edge input (north_i/south_i by column, east_i/west_i by row); a tied-low edge input gives 0.
- R5: The edge outputs show mem[addr_b_i] of the border elements combinationally: north_o[c] from row 0, south_o[c] from the last row, east_o[r] from the last column, west_o[r] from column 0.
- R6: In an element whose activity flag is 0, a logic op changes neither memory nor carry.
- R7: op_i=3 (flag load): every element, active or not, sets its flag to sum_tt_i[idx]; memory and carry are unchanged.
- R8: op_i=2 (shift): every element, regardless of its flag, writes its west neighbour's bit at addr_b_i into mem[dst_i]; column 0 takes west_i. With dst_i equal to addr_b_i a row moves one column east per cycle and leaves on east_o.
- R9: op_i=0 (no-op) changes no state.
- R10: The carry bit persists between instructions, so a chain of logic ops with sum table 0x96 and carry table 0xE8, after the carry has been cleared, adds two bit-serial operands of any width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Broadcast operation: 0 no-op, 1 logic, 2 shift, 3 flag load |
| addr_a_i | input | AW | Memory row read as operand a |
| addr_b_i | input | AW | Memory row read for neighbour exchange and edge outputs |
| dst_i | input | AW | Memory row written |
| nsel_i | input | 3 | Neighbour select code |
| sum_tt_i | input | 8 | Truth table for the written bit and the flag |
| carry_tt_i | input | 8 | Truth table for the next carry |
| north_i | input | COLS | Bits from the array above, one per column |
| south_i | input | COLS | Bits from the array below, one per column |
| east_i | input | ROWS | Bits from the array to the east, one per row |
| west_i | input | ROWS | Bits from the array to the west, and shift input, one per row |
| north_o | output | COLS | Row 0 bits at addr_b_i |
| south_o | output | COLS | Last-row bits at addr_b_i |
| east_o | output | ROWS | Last-column bits at addr_b_i, and shift output |
| west_o | output | ROWS | Column 0 bits at addr_b_i |

## Verification
On every cycle the assertions check five things. A no-op keeps the edge view still. A shift moves the west edge input into column 0. A masked logic op leaves the array untouched. A fully active constant write drives the whole edge view to ones. A north-sourced copy reproduces north_i on row 0. Interior behaviour is visible only through the shift path, so only the bench's scenarios can show it. These scenarios cover the neighbour routing inside the mesh, the ripple-carry addition over eight bit rows, the two-stage majority smoothing, and the data-dependent masking set up by a flag load.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_LOGIC = 2'd1,
    OP_SHIFT = 2'd2,
    OP_FLAG  = 2'd3
  } pa_op_e;

  typedef enum logic [2:0] {
    NB_SELF = 3'd0,
    NB_N    = 3'd1,
    NB_E    = 3'd2,
    NB_S    = 3'd3,
    NB_W    = 3'd4
  } pa_nsel_e;

  function automatic logic lut3(input logic [7:0] tt, input logic a, input logic n, input logic c);
    return tt[{a, n, c}];
  endfunction
endpackage

// File: rtl/pa_bit_column.sv
module pa_bit_column #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_a_addr_i,
  input  logic [AW-1:0] rd_b_addr_i,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  output logic          rd_a_o,
  output logic          rd_b_o
);
  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else if (we_i) bits_q[wr_addr_i] <= wr_bit_i;
  end

  assign rd_a_o = bits_q[rd_a_addr_i];
  assign rd_b_o = bits_q[rd_b_addr_i];
endmodule

// File: rtl/pa_nb_sel.sv
module pa_nb_sel
  import pa_pkg::*;
(
  input  logic [2:0] nsel_i,
  input  logic       own_i,
  input  logic       nb_n_i,
  input  logic       nb_e_i,
  input  logic       nb_s_i,
  input  logic       nb_w_i,
  output logic       nb_o
);
  always_comb begin
    case (nsel_i)
      NB_N:    nb_o = nb_n_i;
      NB_E:    nb_o = nb_e_i;
      NB_S:    nb_o = nb_s_i;
      NB_W:    nb_o = nb_w_i;
      default: nb_o = own_i;
    endcase
  end
endmodule

// File: rtl/pa_pe.sv
module pa_pe
  import pa_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_a_i,
  input  logic [AW-1:0] addr_b_i,
  input  logic [AW-1:0] dst_i,
  input  logic [2:0]    nsel_i,
  input  logic [7:0]    sum_tt_i,
  input  logic [7:0]    carry_tt_i,
  input  logic          nb_n_i,
  input  logic          nb_e_i,
  input  logic          nb_s_i,
  input  logic          nb_w_i,
  output logic          bit_b_o
);
  pa_op_e op;
  logic   rd_a, rd_b, nb, res, we, wr_bit;
  logic   carry_q, flag_q;

  assign op = pa_op_e'(op_i);

  pa_bit_column #(.DEPTH(DEPTH)) col_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_addr_i(addr_a_i),
    .rd_b_addr_i(addr_b_i),
    .we_i       (we),
    .wr_addr_i  (dst_i),
    .wr_bit_i   (wr_bit),
    .rd_a_o     (rd_a),
    .rd_b_o     (rd_b)
  );

  pa_nb_sel nbsel_i (
    .nsel_i(nsel_i),
    .own_i (rd_b),
    .nb_n_i(nb_n_i),
    .nb_e_i(nb_e_i),
    .nb_s_i(nb_s_i),
    .nb_w_i(nb_w_i),
    .nb_o  (nb)
  );

  assign res = lut3(sum_tt_i, rd_a, nb, carry_q);

  // shift ignores the flag so image load/unload always reaches every pixel
  assign we     = ((op == OP_LOGIC) && flag_q) || (op == OP_SHIFT);
  assign wr_bit = (op == OP_SHIFT) ? nb_w_i : res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      flag_q  <= 1'b1;
    end else begin
      if ((op == OP_LOGIC) && flag_q) carry_q <= lut3(carry_tt_i, rd_a, nb, carry_q);
      if (op == OP_FLAG) flag_q <= res;
    end
  end

  assign bit_b_o = rd_b;
endmodule

// File: rtl/pixel_array.sv
module pixel_array #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      op_i,
  input  logic [AW-1:0]   addr_a_i,
  input  logic [AW-1:0]   addr_b_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [2:0]      nsel_i,
  input  logic [7:0]      sum_tt_i,
  input  logic [7:0]      carry_tt_i,
  input  logic [COLS-1:0] north_i,
  input  logic [COLS-1:0] south_i,
  input  logic [ROWS-1:0] east_i,
  input  logic [ROWS-1:0] west_i,
  output logic [COLS-1:0] north_o,
  output logic [COLS-1:0] south_o,
  output logic [ROWS-1:0] east_o,
  output logic [ROWS-1:0] west_o
);
  logic bb    [ROWS][COLS];
  logic nb_n  [ROWS][COLS];
  logic nb_e  [ROWS][COLS];
  logic nb_s  [ROWS][COLS];
  logic nb_w  [ROWS][COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (r == 0) begin : g_n_edge
        assign nb_n[r][c] = north_i[c];
      end else begin : g_n_mesh
        assign nb_n[r][c] = bb[r-1][c];
      end
      if (r == ROWS - 1) begin : g_s_edge
        assign nb_s[r][c] = south_i[c];
      end else begin : g_s_mesh
        assign nb_s[r][c] = bb[r+1][c];
      end
      if (c == COLS - 1) begin : g_e_edge
        assign nb_e[r][c] = east_i[r];
      end else begin : g_e_mesh
        assign nb_e[r][c] = bb[r][c+1];
      end
      if (c == 0) begin : g_w_edge
        assign nb_w[r][c] = west_i[r];
      end else begin : g_w_mesh
        assign nb_w[r][c] = bb[r][c-1];
      end

      pa_pe #(.DEPTH(DEPTH)) pe_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .op_i      (op_i),
        .addr_a_i  (addr_a_i),
        .addr_b_i  (addr_b_i),
        .dst_i     (dst_i),
        .nsel_i    (nsel_i),
        .sum_tt_i  (sum_tt_i),
        .carry_tt_i(carry_tt_i),
        .nb_n_i    (nb_n[r][c]),
        .nb_e_i    (nb_e[r][c]),
        .nb_s_i    (nb_s[r][c]),
        .nb_w_i    (nb_w[r][c]),
        .bit_b_o   (bb[r][c])
      );
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_ns_out
    assign north_o[c] = bb[0][c];
    assign south_o[c] = bb[ROWS-1][c];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_ew_out
    assign east_o[r] = bb[r][COLS-1];
    assign west_o[r] = bb[r][0];
  end
endmodule

// File: rtl/pixel_array_chk.sv
module pixel_array_chk #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      op_i,
  input logic [AW-1:0]   addr_b_i,
  input logic [AW-1:0]   dst_i,
  input logic [2:0]      nsel_i,
  input logic [7:0]      sum_tt_i,
  input logic [COLS-1:0] north_i,
  input logic [ROWS-1:0] west_i,
  input logic [COLS-1:0] north_o,
  input logic [COLS-1:0] south_o,
  input logic [ROWS-1:0] east_o,
  input logic [ROWS-1:0] west_o
);
  // observer: flags known all set / all clear from the last flag load
  logic all_on_q, none_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_on_q  <= 1'b1;
      none_on_q <= 1'b0;
    end else if (op_i == 2'd3) begin
      all_on_q  <= (sum_tt_i == 8'hFF);
      none_on_q <= (sum_tt_i == 8'h00);
    end
  end

  a_r9_nop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd0) |=> (!$stable(addr_b_i) ||
      ($stable(north_o) && $stable(south_o) && $stable(east_o) && $stable(west_o))));

  a_r8_shift_enters_west: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 2'd2 && dst_i == addr_b_i) |=>
      (!$stable(addr_b_i) || (west_o == $past(west_i))));

  a_r6_masked_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (none_on_q && op_i == 2'd1) |=> (!$stable(addr_b_i) ||
      ($stable(north_o) && $stable(south_o) && $stable(east_o) && $stable(west_o))));

  a_r2_const_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_on_q && op_i == 2'd1 && sum_tt_i == 8'hFF && dst_i == addr_b_i) |=>
      (!$stable(addr_b_i) || (&{north_o, south_o, east_o, west_o})));

  a_r4_north_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_on_q && op_i == 2'd1 && nsel_i == 3'd1 && sum_tt_i == 8'hCC && dst_i == addr_b_i) |=>
      (!$stable(addr_b_i) || (north_o == $past(north_i))));
endmodule

bind pixel_array pixel_array_chk #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .addr_b_i(addr_b_i),
  .dst_i   (dst_i),
  .nsel_i  (nsel_i),
  .sum_tt_i(sum_tt_i),
  .north_i (north_i),
  .west_i  (west_i),
  .north_o (north_o),
  .south_o (south_o),
  .east_o  (east_o),
  .west_o  (west_o)
);

// File: tb/pixel_array_tb_top.sv
`timescale 1ns/1ps
module pixel_array_tb_top;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int DEPTH = 128;
  localparam int AW = 7;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      op = '0;
  logic [AW-1:0]   aa = '0, ab = '0, ad = '0;
  logic [2:0]      ns = '0;
  logic [7:0]      stt = '0, ctt = '0;
  logic [COLS-1:0] n_i = '0, s_i = '0, n_o, s_o;
  logic [ROWS-1:0] e_i = '0, w_i = '0, e_o, w_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_mem [ROWS][COLS][DEPTH];
  bit m_c   [ROWS][COLS];
  bit m_f   [ROWS][COLS];
  bit got   [ROWS][COLS];

  always #2.5 clk_i = ~clk_i;

  pixel_array #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .addr_a_i(aa), .addr_b_i(ab),
    .dst_i(ad), .nsel_i(ns), .sum_tt_i(stt), .carry_tt_i(ctt),
    .north_i(n_i), .south_i(s_i), .east_i(e_i), .west_i(w_i),
    .north_o(n_o), .south_o(s_o), .east_o(e_o), .west_o(w_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int val(input int which, input int r, input int c);
    if (which == 0) return (r * 37 + c * 91 + 13) & 255;
    return (r * 53 + c * 29 + 200) & 255;
  endfunction

  function automatic bit m_nbr(input int r, input int c, input int sel);
    case (sel)
      1: if (r == 0) return n_i[c]; else return m_mem[r-1][c][ab];
      2: if (c == COLS - 1) return e_i[r]; else return m_mem[r][c+1][ab];
      3: if (r == ROWS - 1) return s_i[c]; else return m_mem[r+1][c][ab];
      4: if (c == 0) return w_i[r]; else return m_mem[r][c-1][ab];
      default: return m_mem[r][c][ab];
    endcase
  endfunction

  task automatic model_update();
    bit nm [ROWS][COLS][DEPTH];
    bit nc [ROWS][COLS];
    bit nf [ROWS][COLS];
    nm = m_mem; nc = m_c; nf = m_f;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        bit a, n;
        logic [2:0] idx;
        a = m_mem[r][c][aa];
        n = m_nbr(r, c, int'(ns));
        idx = {a, n, m_c[r][c]};
        case (op)
          2'd1: if (m_f[r][c]) begin
            nm[r][c][ad] = stt[idx];
            nc[r][c] = ctt[idx];
          end
          2'd2: nm[r][c][ad] = m_nbr(r, c, 4);
          2'd3: nf[r][c] = stt[idx];
          default: ;
        endcase
      end
    end
    m_mem = nm; m_c = nc; m_f = nf;
  endtask

  // compare full edge view against model, then clock once
  task automatic step(input string tag);
    logic [COLS-1:0] en, es;
    logic [ROWS-1:0] ee, ew;
    #1;
    for (int c = 0; c < COLS; c++) begin
      en[c] = m_mem[0][c][ab];
      es[c] = m_mem[ROWS-1][c][ab];
    end
    for (int r = 0; r < ROWS; r++) begin
      ee[r] = m_mem[r][COLS-1][ab];
      ew[r] = m_mem[r][0][ab];
    end
    check({n_o, s_o, e_o, w_o} == {en, es, ee, ew}, {tag, " R5 edge view"},
          32'({n_o, s_o, e_o, w_o}), 32'({en, es, ee, ew}));
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
  endtask

  task automatic set_ins(input logic [1:0] o, input int a, input int b, input int d,
                         input int nsel, input logic [7:0] st, input logic [7:0] ct);
    op = o; aa = AW'(a); ab = AW'(b); ad = AW'(d); ns = 3'(nsel); stt = st; ctt = ct;
  endtask

  task automatic load_row(input int addr, input int which, input int bitn);
    for (int k = 0; k < COLS; k++) begin
      set_ins(2'd2, 0, addr, addr, 0, 8'h00, 8'h00);
      for (int r = 0; r < ROWS; r++) w_i[r] = 1'((val(which, r, COLS - 1 - k) >> bitn) & 1);
      step("R8 load");
    end
    w_i = '0;
  endtask

  task automatic readout(input int addr);
    w_i = '0;
    for (int k = 0; k < COLS; k++) begin
      set_ins(2'd2, 0, addr, addr, 0, 8'h00, 8'h00);
      #1;
      for (int r = 0; r < ROWS; r++) got[r][COLS-1-k] = e_o[r];
      step("R8 unload");
    end
  endtask

  function automatic bit pix(input int r, input int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
    return 1'(val(0, r, c) & 1);
  endfunction

  function automatic bit maj(input bit x, input bit y, input bit z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic bit vmaj(input int r, input int c);
    if (c < 0 || c >= COLS) return 0;
    return maj(pix(r - 1, c), pix(r, c), pix(r + 1, c));
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        m_c[r][c] = 0;
        m_f[r][c] = 1;
        for (int d = 0; d < DEPTH; d++) m_mem[r][c][d] = 0;
      end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset state seen through edges
    for (int a = 0; a < DEPTH; a += 37) begin
      set_ins(2'd0, 0, a, 0, 0, 8'h00, 8'h00);
      #1;
      check({n_o, s_o, e_o, w_o} == '0, "R1 reset zero", 32'({n_o, s_o, e_o, w_o}), 0);
      step("R1");
    end

    // load operands A rows 0..7, B rows 8..15
    for (int i = 0; i < 8; i++) begin
      load_row(i, 0, i);
      load_row(8 + i, 1, i);
    end

    // R10: clear carry, then ripple add
    set_ins(2'd1, 0, 0, 0, 0, 8'hF0, 8'h00);
    step("R2 carry clear");
    for (int i = 0; i < 8; i++) begin
      set_ins(2'd1, i, 8 + i, 16 + i, 0, 8'h96, 8'hE8);
      step("R10 add bit");
    end
    for (int i = 0; i < 8; i++) begin
      readout(16 + i);
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++) begin
          bit e;
          e = 1'((((val(0, r, c) + val(1, r, c)) & 255) >> i) & 1);
          check(got[r][c] == e, "R10 sum bit", 32'(got[r][c]), 32'(e));
        end
    end

    // R4: edge inputs feed border elements
    n_i = 4'b1010; s_i = 4'b0110; e_i = 4'b1001; w_i = 4'b0011;
    set_ins(2'd1, 0, 1, 40, 1, 8'hCC, 8'hAA); step("R3 north");
    set_ins(2'd1, 0, 1, 41, 3, 8'hCC, 8'hAA); step("R3 south");
    set_ins(2'd1, 0, 1, 42, 4, 8'hCC, 8'hAA); step("R3 west");
    set_ins(2'd1, 0, 1, 43, 2, 8'hCC, 8'hAA); step("R3 east");
    set_ins(2'd0, 0, 40, 0, 0, 8'h00, 8'h00); #1;
    check(n_o == n_i, "R4 north edge", 32'(n_o), 32'(n_i)); step("R9");
    set_ins(2'd0, 0, 41, 0, 0, 8'h00, 8'h00); #1;
    check(s_o == s_i, "R4 south edge", 32'(s_o), 32'(s_i)); step("R9");
    set_ins(2'd0, 0, 42, 0, 0, 8'h00, 8'h00); #1;
    check(w_o == w_i, "R4 west edge", 32'(w_o), 32'(w_i)); step("R9");
    set_ins(2'd0, 0, 43, 0, 0, 8'h00, 8'h00); #1;
    check(e_o == e_i, "R4 east edge", 32'(e_o), 32'(e_i)); step("R9");
    n_i = '0; s_i = '0; e_i = '0; w_i = '0;
    set_ins(2'd1, 0, 1, 40, 1, 8'hCC, 8'hAA); step("R4 tie low");
    set_ins(2'd0, 0, 40, 0, 0, 8'h00, 8'h00); #1;
    check(n_o == '0, "R4 tied-low north", 32'(n_o), 0); step("R9");

    // R3: interior east link, row 44 = east neighbour of A bit 0
    set_ins(2'd1, 0, 0, 44, 2, 8'hCC, 8'hAA); step("R3 east copy");
    readout(44);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        bit e;
        e = pix(r, c + 1);
        check(got[r][c] == e, "R3 east neighbour", 32'(got[r][c]), 32'(e));
      end

    // smoothing: vertical then horizontal 3-tap majority of A bit 0
    set_ins(2'd1, 0, 0, 0, 1, 8'hF0, 8'hCC);   step("R3 smooth c<=N");
    set_ins(2'd1, 0, 0, 50, 3, 8'hE8, 8'hAA);  step("R3 smooth vert");
    set_ins(2'd1, 50, 50, 50, 4, 8'hF0, 8'hCC); step("R3 smooth c<=W");
    set_ins(2'd1, 50, 50, 51, 2, 8'hE8, 8'hAA); step("R3 smooth horiz");
    readout(51);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        bit e;
        e = maj(vmaj(r, c - 1), vmaj(r, c), vmaj(r, c + 1));
        check(got[r][c] == e, "R3 smoothing", 32'(got[r][c]), 32'(e));
      end

    // R6/R7: flag from B bit 0, masked constant write
    set_ins(2'd3, 8, 0, 0, 0, 8'hF0, 8'h00); step("R7 flag load");
    set_ins(2'd1, 0, 0, 60, 0, 8'hFF, 8'hAA); step("R6 masked write");
    set_ins(2'd3, 0, 0, 0, 0, 8'h00, 8'h00); step("R7 all off");
    set_ins(2'd1, 0, 60, 60, 0, 8'h00, 8'h00); step("R6 none active");
    set_ins(2'd1, 0, 60, 60, 0, 8'h00, 8'h00); step("R6 none active");
    set_ins(2'd3, 0, 0, 0, 0, 8'hFF, 8'h00); step("R7 all on");
    set_ins(2'd1, 0, 61, 61, 0, 8'hFF, 8'hAA); step("R2 const");
    set_ins(2'd0, 0, 61, 0, 0, 8'h00, 8'h00); #1;
    check(&{n_o, s_o, e_o, w_o}, "R2 all ones", 32'({n_o, s_o, e_o, w_o}), 32'h0000_FFFF);
    step("R9");
    readout(60);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        bit e;
        e = 1'(val(1, r, c) & 1);
        check(got[r][c] == e, "R6 masked write", 32'(got[r][c]), 32'(e));
      end

    // R9: no-ops with busy control fields
    for (int k = 0; k < 6; k++) begin
      set_ins(2'd0, k, 8 + k, 8 + k, k, 8'h5A + 8'(k), 8'hC3);
      step("R9 nop");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule